// File: doc/BRIEF.md
# Serial Floating-Point Audio Sample Receiver

This block sits beside an FM synthesis chip and turns the chip's serial audio stream into plain 16-bit signed samples in the system clock domain. It also makes the chip's master clock by dividing the fast system clock down to about 3.58 MHz.

The chip sends a bit clock, a frame signal and a serial data line. All three are asynchronous to the system clock. They pass through a synchroniser, and bits are taken on rising edges of the bit clock. Every change of the frame signal closes a frame. A frame holding exactly eighteen bits is accepted. Its five leading filler bits are dropped. The thirteen bits that remain form a compact floating-point code: a ten-bit offset-binary mantissa and a three-bit exponent. The block expands this code into a linear two's-complement value, presents it on the sample output and raises a valid strobe for one system clock.

Top module: `fsr_sample_rx`

## Requirements
- R1: While reset is held and after it is released, `sample_o` is 0 and `sample_vld_o` is 0 until the first accepted frame; `mclk_o` starts low.
- R2: `mclk_o` has a period of round(SYS_HZ / MCLK_HZ) system clocks, which is 14 by default. The period splits into 7 cycles high and 7 cycles low. With an odd divisor the high phase is one cycle longer.
- R3: Data bits are taken on rising edges of `bclk_i`. The first five bits of each frame are filler, and their values have no effect on the decoded sample.
- R4: Within the thirteen meaningful bits, which arrive least significant first, code bits 0 to 9 are the mantissa and code bits 10 to 12 are the exponent.
- R5: The mantissa is offset binary: its signed value is mantissa minus 512.
- R6: An exponent of 0 gives a sample of 0, whatever the mantissa.
- R7: An exponent e from 1 to 7 gives the sample (mantissa − 512) × 2^(e−1) in 16-bit two's complement. The range is −32768 to 32704.
- R8: A frame that closes with any count other than 18 rising bit-clock edges (0, 17, 19, ...) produces no strobe and leaves `sample_o` unchanged.
- R9: Each accepted frame produces a strobe exactly one system clock long. `sample_o` keeps its value between strobes.
- R10: Both the rising and the falling change of `sync_i` close a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the chip (asynchronous) |
| sync_i | input | 1 | Frame signal; every change closes a frame (asynchronous) |
| sdata_i | input | 1 | Serial sample data, least significant first (asynchronous) |
| mclk_o | output | 1 | Divided master clock for the chip |
| sample_o | output | 16 | Last decoded sample, two's complement |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions assume that each level of `bclk_i` and `sync_i` lasts several system clocks. They also assume that `sdata_i` is stable over the synchroniser delay around each rising bit-clock edge, and that a change of `sync_i` never lands in the same system cycle as a rising bit-clock edge. Under those conditions accepted frames are at least eighteen bit periods apart, so strobes can never sit next to each other.

The stimulus holds every bit-clock phase for four system clocks. It changes data only together with the falling bit clock, and moves `sync_i` four cycles after the last falling edge. Random codes and random filler are mixed with extreme mantissa and exponent values and with short, long and empty frames.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   // Positions of the three serial inputs inside the synchroniser vector
   localparam int unsigned IDX_BCLK = 0;
   localparam int unsigned IDX_SYNC = 1;
   localparam int unsigned IDX_DATA = 2;
   localparam int unsigned N_SER    = 3;

   // Integer divide rounded to nearest
   function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
      return (num + den / 2) / den;
   endfunction

   // Largest left shift produced by an exponent field of the given width
   function automatic int unsigned max_shift(input int unsigned exp_w);
      return (1 << exp_w) - 2;
   endfunction

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("fsr_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe <= {pipe[STAGES-2:0], d_i};
      end
   end

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/fsr_clkdiv.sv
module fsr_clkdiv #(
   parameter int unsigned DIV = 14
) (
   input  logic clk,
   input  logic rst_n,
   output logic mclk_o
);

   localparam int unsigned HI_CYC = (DIV + 1) / 2;
   localparam int unsigned LO_CYC = DIV / 2;
   localparam int unsigned CW     = $clog2(HI_CYC + 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("fsr_clkdiv: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] ph_q;
   logic          mclk_q;
   logic [CW-1:0] ph_last;

   // Odd divisors give the extra cycle to the high phase
   assign ph_last = mclk_q ? CW'(HI_CYC - 1) : CW'(LO_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         mclk_q <= 1'b0;
      end else if (ph_q == ph_last) begin
         ph_q   <= '0;
         mclk_q <= ~mclk_q;
      end else begin
         ph_q   <= ph_q + CW'(1);
      end
   end

   assign mclk_o = mclk_q;

endmodule

// File: rtl/fsr_deser.sv
module fsr_deser #(
   parameter int unsigned FRAME_BITS = 18,
   parameter int unsigned WORD_W     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_s,
   input  logic              sync_s,
   input  logic              data_s,
   output logic [WORD_W-1:0] word_o,
   output logic              word_stb_o
);

   localparam int unsigned CW      = $clog2(FRAME_BITS + 2);
   localparam logic [CW-1:0] C_SAT = CW'(FRAME_BITS + 1);
   localparam logic [CW-1:0] C_FULL = CW'(FRAME_BITS);

   generate
      if (WORD_W >= FRAME_BITS) begin : g_bad_frame
         $error("fsr_deser: FRAME_BITS must exceed WORD_W");
      end
   endgenerate

   logic              bclk_d, sync_d;
   logic              bit_rise, frame_end;
   logic [CW-1:0]     cnt_q;
   logic [WORD_W-1:0] shift_q;

   assign bit_rise  = bclk_s & ~bclk_d;
   assign frame_end = sync_s ^ sync_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d     <= 1'b0;
         sync_d     <= 1'b0;
         cnt_q      <= '0;
         shift_q    <= '0;
         word_o     <= '0;
         word_stb_o <= 1'b0;
      end else begin
         bclk_d     <= bclk_s;
         sync_d     <= sync_s;
         word_stb_o <= 1'b0;
         if (frame_end) begin
            cnt_q <= '0;
            if (cnt_q == C_FULL) begin
               word_o     <= shift_q;
               word_stb_o <= 1'b1;
            end
         end else if (bit_rise) begin
            // least significant first: newest bit enters at the top
            shift_q <= {data_s, shift_q[WORD_W-1:1]};
            if (cnt_q != C_SAT) begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/fsr_fp_decode.sv
module fsr_fp_decode #(
   parameter int unsigned MANT_W = 10,
   parameter int unsigned EXP_W  = 3,
   parameter int unsigned OUT_W  = 16
) (
   input  logic [MANT_W+EXP_W-1:0] code_i,
   output logic [OUT_W-1:0]        value_o
);

   generate
      if (OUT_W < MANT_W + fsr_pkg::max_shift(EXP_W)) begin : g_bad_out
         $error("fsr_fp_decode: OUT_W too narrow for the largest shift");
      end
      if (MANT_W < 2) begin : g_bad_mant
         $error("fsr_fp_decode: MANT_W must be at least 2");
      end
   endgenerate

   logic        [MANT_W-1:0] mant;
   logic        [EXP_W-1:0]  expo;
   logic        [EXP_W-1:0]  shamt;
   logic signed [MANT_W-1:0] mant_s;
   logic signed [OUT_W-1:0]  ext;

   assign mant  = code_i[MANT_W-1:0];
   assign expo  = code_i[MANT_W +: EXP_W];
   assign shamt = expo - EXP_W'(1);

   always_comb begin
      // offset binary to two's complement: flip the top bit
      mant_s  = {~mant[MANT_W-1], mant[MANT_W-2:0]};
      ext     = OUT_W'(mant_s);
      value_o = (expo == '0) ? '0 : OUT_W'(ext <<< shamt);
   end

endmodule

// File: rtl/fsr_sample_rx.sv
module fsr_sample_rx #(
   parameter int unsigned SYS_HZ      = 50_000_000,
   parameter int unsigned MCLK_HZ     = 3_580_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FRAME_BITS  = 18,
   parameter int unsigned PAD_BITS    = 5,
   parameter int unsigned MANT_W      = 10,
   parameter int unsigned EXP_W       = 3,
   parameter int unsigned OUT_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             sync_i,
   input  logic             sdata_i,
   output logic             mclk_o,
   output logic [OUT_W-1:0] sample_o,
   output logic             sample_vld_o
);

   localparam int unsigned WORD_W = MANT_W + EXP_W;
   localparam int unsigned DIV    = fsr_pkg::round_div(SYS_HZ, MCLK_HZ);
   localparam int unsigned HI_CYC = (DIV + 1) / 2;
   localparam int unsigned LO_CYC = DIV / 2;

   generate
      if (PAD_BITS + WORD_W != FRAME_BITS) begin : g_bad_layout
         $error("fsr_sample_rx: PAD_BITS + MANT_W + EXP_W must equal FRAME_BITS");
      end
      if (MCLK_HZ == 0 || MCLK_HZ > SYS_HZ / 2) begin : g_bad_clk
         $error("fsr_sample_rx: MCLK_HZ out of range");
      end
   endgenerate

   logic [fsr_pkg::N_SER-1:0] ser_raw, ser_s;
   logic [WORD_W-1:0]         frame_word;
   logic                      frame_stb;
   logic [OUT_W-1:0]          dec_value;

   assign ser_raw[fsr_pkg::IDX_BCLK] = bclk_i;
   assign ser_raw[fsr_pkg::IDX_SYNC] = sync_i;
   assign ser_raw[fsr_pkg::IDX_DATA] = sdata_i;

   fsr_sync #(
      .W      (fsr_pkg::N_SER),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ser_raw),
      .q_o   (ser_s)
   );

   fsr_clkdiv #(
      .DIV (DIV)
   ) u_clkdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .mclk_o (mclk_o)
   );

   fsr_deser #(
      .FRAME_BITS (FRAME_BITS),
      .WORD_W     (WORD_W)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_s     (ser_s[fsr_pkg::IDX_BCLK]),
      .sync_s     (ser_s[fsr_pkg::IDX_SYNC]),
      .data_s     (ser_s[fsr_pkg::IDX_DATA]),
      .word_o     (frame_word),
      .word_stb_o (frame_stb)
   );

   fsr_fp_decode #(
      .MANT_W (MANT_W),
      .EXP_W  (EXP_W),
      .OUT_W  (OUT_W)
   ) u_decode (
      .code_i  (frame_word),
      .value_o (dec_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_o     <= '0;
         sample_vld_o <= 1'b0;
      end else begin
         sample_vld_o <= frame_stb;
         if (frame_stb) begin
            sample_o <= dec_value;
         end
      end
   end

endmodule

// File: rtl/fsr_rx_checker.sv
module fsr_rx_checker #(
   parameter int unsigned HI_CYC = 7,
   parameter int unsigned LO_CYC = 7,
   parameter int unsigned MANT_W = 10,
   parameter int unsigned EXP_W  = 3,
   parameter int unsigned OUT_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mclk_o,
   input logic [OUT_W-1:0]        sample_o,
   input logic                    sample_vld_o,
   input logic [MANT_W+EXP_W-1:0] frame_word
);

   localparam int unsigned RW = $clog2(HI_CYC + 2) + 1;

   logic          mclk_p;
   logic [RW-1:0] run_q;
   logic [EXP_W-1:0] expo;

   assign expo = frame_word[MANT_W +: EXP_W];

   // length of the current master-clock phase, counted in the checker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mclk_p <= 1'b0;
         run_q  <= '0;
      end else begin
         mclk_p <= mclk_o;
         run_q  <= (mclk_o != mclk_p) ? RW'(1) : run_q + RW'(1);
      end
   end

   // R2: each completed phase has its required length
   a_r2_mclk_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (mclk_o != mclk_p) |-> (run_q == (mclk_p ? RW'(HI_CYC) : RW'(LO_CYC))));

   // R9: strobe lasts a single cycle
   a_r9_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |=> !sample_vld_o);

   // R9: output held between strobes
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_vld_o |-> $stable(sample_o));

   // R6: zero exponent yields zero
   a_r6_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld_o && expo == '0) |-> (sample_o == '0));

   // R7: exponent of 2 or more leaves the lowest bit clear
   a_r7_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld_o && expo >= EXP_W'(2)) |-> (sample_o[0] == 1'b0));

endmodule

bind fsr_sample_rx fsr_rx_checker #(
   .HI_CYC (HI_CYC),
   .LO_CYC (LO_CYC),
   .MANT_W (MANT_W),
   .EXP_W  (EXP_W),
   .OUT_W  (OUT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mclk_o       (mclk_o),
   .sample_o     (sample_o),
   .sample_vld_o (sample_vld_o),
   .frame_word   (frame_word)
);

// File: tb/fsr_sample_rx_bench.sv
module fsr_sample_rx_bench;

   localparam int unsigned SYS_HZ  = 50_000_000;
   localparam int unsigned MCLK_HZ = 3_580_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        fsync = 1'b0;
   logic        sdat = 1'b0;
   logic        mclk;
   logic [15:0] sample;
   logic        vld;

   int checks = 0;
   int errors = 0;
   logic [15:0] last_val = 16'h0;

   always #10 clk = ~clk;

   fsr_sample_rx u_fsr_sample_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .bclk_i       (bclk),
      .sync_i       (fsync),
      .sdata_i      (sdat),
      .mclk_o       (mclk),
      .sample_o     (sample),
      .sample_vld_o (vld)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] ref_val(input logic [12:0] w);
      int m, e, v;
      m = int'(w[9:0]);
      e = int'(w[12:10]);
      if (e == 0) return 16'h0;
      v = (m - 512) * (1 << (e - 1));
      return v[15:0];
   endfunction

   task automatic send_bits(input logic [31:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         sdat = bits[i];
         bclk = 1'b0;
         tick(4);
         bclk = 1'b1;
         tick(4);
      end
      bclk = 1'b0;
      tick(4);
      fsync = ~fsync;
   endtask

   task automatic expect_sample(input logic [12:0] w, input string tag);
      logic [15:0] exp_v;
      bit seen = 0;
      exp_v = ref_val(w);
      for (int i = 0; i < 30 && !seen; i++) begin
         tick(1);
         if (vld) seen = 1;
      end
      check(seen, {tag, " strobe"}, int'(seen), 1);
      if (seen) begin
         check(sample == exp_v, tag, int'($signed(sample)), int'($signed(exp_v)));
         last_val = exp_v;
         tick(1);
         check(!vld, "R9 strobe one cycle", int'(vld), 0);
         check(sample == exp_v, "R9 sample held", int'($signed(sample)), int'($signed(exp_v)));
      end
   endtask

   task automatic expect_none(input string tag);
      bit seen = 0;
      for (int i = 0; i < 30; i++) begin
         tick(1);
         if (vld) seen = 1;
      end
      check(!seen, tag, int'(seen), 0);
      check(sample == last_val, {tag, " sample unchanged"}, int'($signed(sample)), int'($signed(last_val)));
   endtask

   task automatic good_frame(input logic [4:0] pad, input logic [12:0] w, input string tag);
      send_bits({14'h0, w, pad}, 18);
      expect_sample(w, tag);
   endtask

   initial begin
      int div, hi_exp, lo_exp, hi_n, lo_n;
      logic [12:0] w;
      logic [4:0]  pad;
      void'($urandom(32'd7331));

      tick(3);
      // R1: reset state
      check(sample == 16'h0, "R1 sample in reset", int'(sample), 0);
      check(!vld, "R1 strobe in reset", int'(vld), 0);
      check(!mclk, "R1 mclk low in reset", int'(mclk), 0);
      rst_n = 1'b1;
      tick(2);
      check(sample == 16'h0 && !vld, "R1 after release", int'(sample), 0);

      // R2: master clock period
      div    = int'((SYS_HZ + MCLK_HZ / 2) / MCLK_HZ);
      hi_exp = (div + 1) / 2;
      lo_exp = div / 2;
      for (int p = 0; p < 3; p++) begin
         while (mclk) tick(1);
         while (!mclk) tick(1);
         hi_n = 0;
         while (mclk) begin hi_n++; tick(1); end
         lo_n = 0;
         while (!mclk) begin lo_n++; tick(1); end
         check(hi_n == hi_exp, "R2 mclk high cycles", hi_n, hi_exp);
         check(lo_n == lo_exp, "R2 mclk low cycles", lo_n, lo_exp);
      end

      // R4 R5 R7 directed extremes; R10 each alternate frame uses the other sync edge
      good_frame(5'h00, {3'd7, 10'd0},    "R7 most negative");
      good_frame(5'h1F, {3'd7, 10'd1023}, "R7 most positive");
      good_frame(5'h0A, {3'd1, 10'd513},  "R5 exp1 plus one");
      good_frame(5'h15, {3'd1, 10'd511},  "R5 exp1 minus one");
      good_frame(5'h03, {3'd3, 10'd512},  "R5 midpoint zero");
      good_frame(5'h1C, {3'd0, 10'd1023}, "R6 exp zero");
      good_frame(5'h07, {3'd4, 10'h2A5},  "R4 field positions");
      // R3: same code under two different fillers
      good_frame(5'h00, {3'd5, 10'h1C3},  "R3 filler zeros");
      good_frame(5'h1F, {3'd5, 10'h1C3},  "R3 filler ones");

      // R8: malformed frames
      send_bits(32'h0003_FFFF, 17);
      expect_none("R8 short frame");
      send_bits(32'h0007_FFFF, 19);
      expect_none("R8 long frame");
      send_bits(32'h0, 0);
      expect_none("R8 empty frame");
      good_frame(5'h11, {3'd2, 10'd700},  "R8 recovery after bad frames");

      // Random frames
      for (int k = 0; k < 50; k++) begin
         w   = 13'($urandom);
         pad = 5'($urandom);
         if (k % 10 == 9) begin
            send_bits(32'($urandom) & 32'h0000_FFFF, 16);
            expect_none("R8 random short frame");
         end
         good_frame(pad, w, "R7 random code");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule